// File: doc/BRIEF.md
# Register Pointer and Selection Unit

This unit holds the small pointer registers that decide which general-purpose register a datapath uses. It keeps a 4-bit selection register that feeds the register file's select lines, a paired instruction-nibble store (I, N), two 4-bit pointers (X, P), and an 8-bit temporary (T) that saves X and P together. A 4-bit register-address bus links the pointers to the selection register. An 8-bit data bus loads values into the unit and carries T back out.

Per-cycle control strobes decide which sources drive the register-address bus and which registers capture values. Hard presets give the selection register a known value of 0 or 2, and set P to 1 and X to 2, in one cycle. These are the states a sequencer needs after reset or on entry to an interrupt. All register updates happen on the rising clock edge. The address bus, the 3-bit N output and the data-bus output are combinational.

Top module: `regptr_unit`

## Requirements
- R1: While `rst_n` is low, and for two clock edges after it rises, sel, i_val, n_val, x_val, p_val and the internal T register are 0, so `data_out` reads 0 and `data_oe` is 0.
- R2: With `sel_load` high and neither preset strobe high, `sel` takes the value of `ra_bus` at the next edge. With no selection strobe high, `sel` holds its value.
- R3: `sel_two` sets `sel` to 2 at the next edge and overrides `sel_clr` and `sel_load`. `sel_clr` without `sel_two` sets `sel` to 0 and overrides `sel_load`.
- R4: `in_load` captures `data_in[7:4]` into I and `data_in[3:0]` into N at the next edge. `in_clr` sets both to 0 and overrides `in_load`.
- R5: `n_low` equals `n_val[2:0]` while `n_out_en` is high, and 0 otherwise, in the same cycle.
- R6: `ra_bus` carries N when `n_drive` is high. Otherwise it carries X when `x_drive` is high, then P when `p_drive` is high. With no driver enabled it carries `ra_ext`.
- R7: `x_ld_ra` (`p_ld_ra`) loads X (P) from `ra_bus`. `x_ld_db` (`p_ld_db`) loads it from `data_in[3:0]`. The bus load wins when both are high. With no load or preset strobe, the pointer holds.
- R8: `preset_px` sets P to 1 and X to 2 at the next edge and overrides every other X and P load.
- R9: `t_load` captures T = {X, P} at the next edge, with X in bits 7:4 and P in bits 3:0, using the values before that edge. No other input changes T.
- R10: `data_out` equals T and `data_oe` is 1 while `t_drive` is high. Otherwise both are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ra_ext | input | 4 | Register-address bus value when no pointer drives it |
| data_in | input | 8 | Data bus into the unit |
| sel_clr | input | 1 | Force selection to 0 |
| sel_two | input | 1 | Force selection to 2 |
| sel_load | input | 1 | Load selection from the address bus |
| in_load | input | 1 | Load I and N from data_in |
| in_clr | input | 1 | Clear I and N |
| n_drive | input | 1 | Drive N onto the address bus |
| n_out_en | input | 1 | Enable the 3-bit N output |
| x_drive | input | 1 | Drive X onto the address bus |
| p_drive | input | 1 | Drive P onto the address bus |
| x_ld_ra | input | 1 | Load X from the address bus |
| x_ld_db | input | 1 | Load X from data_in[3:0] |
| p_ld_ra | input | 1 | Load P from the address bus |
| p_ld_db | input | 1 | Load P from data_in[3:0] |
| preset_px | input | 1 | Set P=1 and X=2 |
| t_load | input | 1 | Capture {X,P} into T |
| t_drive | input | 1 | Drive T onto data_out |
| sel | output | 4 | Register-file select |
| i_val | output | 4 | I register |
| n_val | output | 4 | N register |
| x_val | output | 4 | X pointer |
| p_val | output | 4 | P pointer |
| n_low | output | 3 | Gated low bits of N |
| ra_bus | output | 4 | Resolved register-address bus |
| data_out | output | 8 | T onto the data bus |
| data_oe | output | 1 | data_out valid |

## Verification
Every register except T is visible at the ports. A wrong next-state value in sel, I, N, X or P therefore shows up as a mismatch one edge after the strobe that caused it. A wrong T shows up only when T is driven, so the bench drives T in the cycle right after each capture. Priority errors among the address-bus drivers, and on the preset paths, show up through `ra_bus` in the same cycle. They also show up one edge later through whichever register loaded the wrong bus value.

// File: rtl/regptr_pkg.sv
package regptr_pkg;
  typedef enum logic [1:0] {
    RA_EXT = 2'd0,
    RA_N   = 2'd1,
    RA_X   = 2'd2,
    RA_P   = 2'd3
  } ra_src_e;
endpackage

// File: rtl/regptr_ra_mux.sv
module regptr_ra_mux
  import regptr_pkg::*;
#(
  parameter int NW = 4
) (
  input  logic          n_drive,
  input  logic          x_drive,
  input  logic          p_drive,
  input  logic [NW-1:0] n_val,
  input  logic [NW-1:0] x_val,
  input  logic [NW-1:0] p_val,
  input  logic [NW-1:0] ra_ext,
  output logic [NW-1:0] ra_bus,
  output ra_src_e       ra_src
);
  // fixed priority: N, then X, then P, then the external value
  always_comb begin
    if (n_drive)      ra_src = RA_N;
    else if (x_drive) ra_src = RA_X;
    else if (p_drive) ra_src = RA_P;
    else              ra_src = RA_EXT;
  end

  always_comb begin
    unique case (ra_src)
      RA_N:    ra_bus = n_val;
      RA_X:    ra_bus = x_val;
      RA_P:    ra_bus = p_val;
      default: ra_bus = ra_ext;
    endcase
  end
endmodule

// File: rtl/regptr_sel_reg.sv
module regptr_sel_reg #(
  parameter int NW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          two,
  input  logic          load,
  input  logic [NW-1:0] ra_bus,
  output logic [NW-1:0] sel
);
  localparam logic [NW-1:0] SEL_TWO = NW'(2);

  logic [NW-1:0] sel_d;
  logic          sel_en;

  always_comb begin
    sel_en = clr | two | load;
    if (two)      sel_d = SEL_TWO;
    else if (clr) sel_d = '0;
    else          sel_d = ra_bus;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sel <= '0;
    else if (sel_en) sel <= sel_d;
  end

  a_r3_two_wins: assert property (@(posedge clk) disable iff (!rst_n)
    two |=> (sel == SEL_TWO));
  a_r3_clr_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !two) |=> (sel == '0));
  a_r2_load_bus: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !clr && !two) |=> (sel == $past(ra_bus)));
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !clr && !two) |=> $stable(sel));
endmodule

// File: rtl/regptr_in_pair.sv
module regptr_in_pair #(
  parameter int NW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            load,
  input  logic [2*NW-1:0] data_in,
  output logic [NW-1:0]   i_q,
  output logic [NW-1:0]   n_q
);
  logic [2*NW-1:0] in_d;
  logic            in_en;

  always_comb begin
    in_en = clr | load;
    in_d  = clr ? '0 : data_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      i_q <= '0;
      n_q <= '0;
    end else if (in_en) begin
      i_q <= in_d[2*NW-1:NW];
      n_q <= in_d[NW-1:0];
    end
  end

  a_r4_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (i_q == '0 && n_q == '0));
  a_r4_load: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !clr) |=> ({i_q, n_q} == $past(data_in)));
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !clr) |=> ($stable(i_q) && $stable(n_q)));
endmodule

// File: rtl/regptr_ptr_reg.sv
module regptr_ptr_reg #(
  parameter int          NW     = 4,
  parameter logic [3:0]  PRESET = 4'd0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          preset,
  input  logic          ld_ra,
  input  logic          ld_db,
  input  logic [NW-1:0] ra_bus,
  input  logic [NW-1:0] db_nib,
  output logic [NW-1:0] q
);
  localparam logic [NW-1:0] PVAL = NW'(PRESET);

  logic [NW-1:0] q_d;
  logic          q_en;

  always_comb begin
    q_en = preset | ld_ra | ld_db;
    if (preset)     q_d = PVAL;
    else if (ld_ra) q_d = ra_bus;
    else            q_d = db_nib;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (q_en) q <= q_d;
  end

  a_r8_preset: assert property (@(posedge clk) disable iff (!rst_n)
    preset |=> (q == PVAL));
  a_r7_bus_first: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_ra && !preset) |=> (q == $past(ra_bus)));
  a_r7_data_load: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_db && !ld_ra && !preset) |=> (q == $past(db_nib)));
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_db && !ld_ra && !preset) |=> $stable(q));
endmodule

// File: rtl/regptr_t_reg.sv
module regptr_t_reg #(
  parameter int NW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic            drive,
  input  logic [NW-1:0]   x_val,
  input  logic [NW-1:0]   p_val,
  output logic [2*NW-1:0] data_out,
  output logic            data_oe
);
  logic [2*NW-1:0] t_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    t_q <= '0;
    else if (load) t_q <= {x_val, p_val};
  end

  always_comb begin
    data_oe  = drive;
    data_out = drive ? t_q : '0;
  end

  a_r9_capture: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (t_q == {$past(x_val), $past(p_val)}));
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(t_q));
  a_r10_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !data_oe |-> (data_out == '0));
endmodule

// File: rtl/regptr_unit.sv
module regptr_unit
  import regptr_pkg::*;
#(
  parameter int NW   = 4,
  parameter int NLOW = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NW-1:0]     ra_ext,
  input  logic [2*NW-1:0]   data_in,
  input  logic              sel_clr,
  input  logic              sel_two,
  input  logic              sel_load,
  input  logic              in_load,
  input  logic              in_clr,
  input  logic              n_drive,
  input  logic              n_out_en,
  input  logic              x_drive,
  input  logic              p_drive,
  input  logic              x_ld_ra,
  input  logic              x_ld_db,
  input  logic              p_ld_ra,
  input  logic              p_ld_db,
  input  logic              preset_px,
  input  logic              t_load,
  input  logic              t_drive,
  output logic [NW-1:0]     sel,
  output logic [NW-1:0]     i_val,
  output logic [NW-1:0]     n_val,
  output logic [NW-1:0]     x_val,
  output logic [NW-1:0]     p_val,
  output logic [NLOW-1:0]   n_low,
  output logic [NW-1:0]     ra_bus,
  output logic [2*NW-1:0]   data_out,
  output logic              data_oe
);
  localparam int NPTR = 2; // index 0 = X, index 1 = P

  // reset: asserted at once, released on the second clock edge
  logic [1:0] rst_sync;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  ra_src_e       ra_src;
  logic [NW-1:0] ptr_q  [NPTR];
  logic          ptr_ra [NPTR];
  logic          ptr_db [NPTR];

  assign ptr_ra[0] = x_ld_ra;
  assign ptr_db[0] = x_ld_db;
  assign ptr_ra[1] = p_ld_ra;
  assign ptr_db[1] = p_ld_db;
  assign x_val     = ptr_q[0];
  assign p_val     = ptr_q[1];

  regptr_ra_mux #(.NW(NW)) u_ra_mux (
    .n_drive (n_drive),
    .x_drive (x_drive),
    .p_drive (p_drive),
    .n_val   (n_val),
    .x_val   (x_val),
    .p_val   (p_val),
    .ra_ext  (ra_ext),
    .ra_bus  (ra_bus),
    .ra_src  (ra_src)
  );

  regptr_sel_reg #(.NW(NW)) u_sel (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .clr    (sel_clr),
    .two    (sel_two),
    .load   (sel_load),
    .ra_bus (ra_bus),
    .sel    (sel)
  );

  regptr_in_pair #(.NW(NW)) u_in (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .clr     (in_clr),
    .load    (in_load),
    .data_in (data_in),
    .i_q     (i_val),
    .n_q     (n_val)
  );

  for (genvar g = 0; g < NPTR; g++) begin : g_ptr
    localparam logic [3:0] PV = (g == 0) ? 4'd2 : 4'd1;
    regptr_ptr_reg #(.NW(NW), .PRESET(PV)) u_ptr (
      .clk    (clk),
      .rst_n  (rst_int_n),
      .preset (preset_px),
      .ld_ra  (ptr_ra[g]),
      .ld_db  (ptr_db[g]),
      .ra_bus (ra_bus),
      .db_nib (data_in[NW-1:0]),
      .q      (ptr_q[g])
    );
  end

  regptr_t_reg #(.NW(NW)) u_t (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .load     (t_load),
    .drive    (t_drive),
    .x_val    (x_val),
    .p_val    (p_val),
    .data_out (data_out),
    .data_oe  (data_oe)
  );

  assign n_low = n_out_en ? n_val[NLOW-1:0] : '0;

  // R6: the bus must follow N whenever N is enabled, whatever else drives
  a_r6_n_first: assert property (@(posedge clk) disable iff (!rst_int_n)
    n_drive |-> (ra_bus == n_val && ra_src == RA_N));
  a_r6_x_over_p: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!n_drive && x_drive) |-> (ra_bus == x_val));
  a_r5_n_low_quiet: assert property (@(posedge clk) disable iff (!rst_int_n)
    !n_out_en |-> (n_low == '0));
  a_r1_reset_state: assert property (@(posedge clk)
    (!rst_int_n) |-> (sel == '0 && i_val == '0 && n_val == '0 && x_val == '0 && p_val == '0));
endmodule

// File: tb/regptr_unit_bench.sv
module regptr_unit_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] ra_ext = '0;
  logic [7:0] data_in = '0;
  logic sel_clr = 0, sel_two = 0, sel_load = 0, in_load = 0, in_clr = 0;
  logic n_drive = 0, n_out_en = 0, x_drive = 0, p_drive = 0;
  logic x_ld_ra = 0, x_ld_db = 0, p_ld_ra = 0, p_ld_db = 0;
  logic preset_px = 0, t_load = 0, t_drive = 0;
  logic [3:0] sel, i_val, n_val, x_val, p_val, ra_bus;
  logic [2:0] n_low;
  logic [7:0] data_out;
  logic       data_oe;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [3:0] m_sel = '0, m_i = '0, m_n = '0, m_x = '0, m_p = '0;
  logic [7:0] m_t = '0;
  logic [31:0] lcg = 32'h1234_5678;

  always #4 clk = ~clk;

  regptr_unit u_regptr_unit (
    .clk(clk), .rst_n(rst_n), .ra_ext(ra_ext), .data_in(data_in),
    .sel_clr(sel_clr), .sel_two(sel_two), .sel_load(sel_load),
    .in_load(in_load), .in_clr(in_clr), .n_drive(n_drive), .n_out_en(n_out_en),
    .x_drive(x_drive), .p_drive(p_drive), .x_ld_ra(x_ld_ra), .x_ld_db(x_ld_db),
    .p_ld_ra(p_ld_ra), .p_ld_db(p_ld_db), .preset_px(preset_px),
    .t_load(t_load), .t_drive(t_drive), .sel(sel), .i_val(i_val), .n_val(n_val),
    .x_val(x_val), .p_val(p_val), .n_low(n_low), .ra_bus(ra_bus),
    .data_out(data_out), .data_oe(data_oe)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle();
    {sel_clr, sel_two, sel_load, in_load, in_clr, n_drive, n_out_en, x_drive,
     p_drive, x_ld_ra, x_ld_db, p_ld_ra, p_ld_db, preset_px, t_load, t_drive} = '0;
  endtask

  // one cycle: check combinational outputs mid-cycle, advance model, check registers
  task automatic tick();
    logic [3:0] ra;
    logic [3:0] nsel, ni, nn, nx, np;
    logic [7:0] nt;
    @(negedge clk);
    ra = n_drive ? m_n : x_drive ? m_x : p_drive ? m_p : ra_ext;
    chk("R6 ra_bus", {4'h0, ra_bus}, {4'h0, ra});
    chk("R5 n_low", {5'h0, n_low}, n_out_en ? {5'h0, m_n[2:0]} : 8'h00);
    chk("R10 data_out", data_out, t_drive ? m_t : 8'h00);
    chk("R10 data_oe", {7'h0, data_oe}, {7'h0, t_drive});
    nsel = sel_two ? 4'd2 : sel_clr ? 4'd0 : sel_load ? ra : m_sel;
    ni = in_clr ? 4'd0 : in_load ? data_in[7:4] : m_i;
    nn = in_clr ? 4'd0 : in_load ? data_in[3:0] : m_n;
    nx = preset_px ? 4'd2 : x_ld_ra ? ra : x_ld_db ? data_in[3:0] : m_x;
    np = preset_px ? 4'd1 : p_ld_ra ? ra : p_ld_db ? data_in[3:0] : m_p;
    nt = t_load ? {m_x, m_p} : m_t;
    @(posedge clk);
    #1;
    m_sel = nsel; m_i = ni; m_n = nn; m_x = nx; m_p = np; m_t = nt;
    chk("R2 R3 sel", {4'h0, sel}, {4'h0, m_sel});
    chk("R4 i_val", {4'h0, i_val}, {4'h0, m_i});
    chk("R4 n_val", {4'h0, n_val}, {4'h0, m_n});
    chk("R7 R8 x_val", {4'h0, x_val}, {4'h0, m_x});
    chk("R7 R8 p_val", {4'h0, p_val}, {4'h0, m_p});
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
  end

  initial begin
    // R1: reset state, including the two-edge synchronous release
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R1 sel", {4'h0, sel}, 8'h00);
    @(posedge clk); #1;
    chk("R1 x_val", {4'h0, x_val}, 8'h00);
    t_drive = 1;
    #1;
    chk("R1 data_out", data_out, 8'h00);
    chk("R1 data_oe", {7'h0, data_oe}, 8'h01);
    idle();
    tick();

    // R4: every data value into I and N, then clear over load
    for (int v = 0; v < 256; v++) begin
      idle(); in_load = 1; data_in = v[7:0]; n_out_en = v[0];
      tick();
    end
    idle(); in_load = 1; in_clr = 1; data_in = 8'hA5; tick();

    // R2 R3: selection from every bus value and the preset priorities
    for (int r = 0; r < 16; r++) begin
      idle(); ra_ext = r[3:0]; sel_load = 1; tick();
      idle(); ra_ext = r[3:0]; sel_load = 1; sel_clr = 1; tick();
      idle(); ra_ext = r[3:0]; sel_load = 1; sel_clr = r[0]; sel_two = 1; tick();
    end

    // R7 R9 R10: every X/P pair loaded from the data bus, captured into T and driven out
    for (int v = 0; v < 256; v++) begin
      idle(); x_ld_db = 1; data_in = {4'h0, v[7:4]}; tick();
      idle(); p_ld_db = 1; data_in = {4'h0, v[3:0]}; tick();
      idle(); t_load = 1; tick();
      idle(); t_drive = 1; preset_px = v[0]; tick();
    end

    // R6 R7 R8: every driver combination with loads from the bus
    for (int c = 0; c < 128; c++) begin
      idle(); in_load = 1; data_in = {c[3:0], ~c[3:0]}; tick();
      idle(); x_ld_db = 1; data_in = {4'h0, c[3:0] ^ 4'h6}; tick();
      idle(); n_drive = c[0]; x_drive = c[1]; p_drive = c[2];
      x_ld_ra = c[3]; p_ld_ra = c[4]; x_ld_db = c[5]; p_ld_db = c[5];
      sel_load = 1; preset_px = c[6]; ra_ext = c[6:3]; data_in = {c[3:0], c[6:3]};
      tick();
    end

    // mixed stimulus over all strobes
    for (int k = 0; k < 3000; k++) begin
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      idle();
      {sel_clr, sel_two, sel_load, in_load, in_clr, n_drive, n_out_en, x_drive} =
        lcg[31:24] & {lcg[7], lcg[6], 1'b1, 1'b1, lcg[5], 1'b1, 1'b1, 1'b1};
      {p_drive, x_ld_ra, x_ld_db, p_ld_ra, p_ld_db, preset_px, t_load, t_drive} =
        lcg[23:16] & {1'b1, 1'b1, 1'b1, 1'b1, 1'b1, lcg[4], 1'b1, 1'b1};
      ra_ext = lcg[15:12];
      data_in = lcg[11:4] ^ lcg[31:24];
      tick();
    end

    idle();
    tick();
    summary();
  end
endmodule